// File: doc/BRIEF.md
# Auxiliary Register Window and RAM Configuration Decoder

This block sits on the CPU write path of a cartridge bank controller. It watches the bus for three kinds of access. The first is writes into the $5000-$5FFF auxiliary window, where four outer-bank control registers live. The second is writes to the dual-purpose $A001 register. The third is accesses to the $6000-$7FFF work-RAM area. It keeps the mode, PRG base, CHR base and extended mode registers, a CHR data latch and the RAM configuration state. It presents all of these as plain fields for the bank arithmetic that sits downstream.

A 3-bit DIP setting decides which address bit must be set for a window write to land. The $A001 register runs a two-state machine with states `CFG_PLAIN` and `CFG_EXT`:

- In `CFG_PLAIN` the register acts as an ordinary RAM enable/write-protect register with a single 8 KiB work-RAM bank.
- In `CFG_EXT` it selects one of four 8 KiB banks and marks the low 8 KiB of CHR space as RAM. It can also hide the auxiliary window, so that window writes are redirected into the upper half of work-RAM bank 2.

The transition `to_ext` is taken on any $A001 write with data bit 5 set. The transition `to_plain` is taken on any $A001 write with bit 5 clear. Otherwise the state holds.

The work-RAM address, chip enable and write enable come from the bus inputs by combinational logic, in the same cycle as the access.

Top module: `aux_window_decoder`

## Requirements
- R1: After reset the mode, CHR base and extended mode registers and the CHR latch are 0, and the PRG base register holds the parameter PRG_BASE_RST (default 0). The RAM configuration is in CFG_PLAIN with wram_en 0, and win_en is 1.
- R2: A write to $5000-$5FFF loads an auxiliary register one cycle later when address bit (4+dip_sel) is 1, address bits 3:2 are 00 and win_en is 1. Address bits 1:0 pick the register: 0 mode, 1 PRG base, 2 CHR base, 3 extended mode.
- R3: A window write whose bit (4+dip_sel) is 0, or whose bits 3:2 are not 00, changes no auxiliary register and no latch.
- R4: An accepted write to the CHR base register clears the CHR latch to 0.
- R5: latch_mode is 1 exactly when mode bit 6 is 1 and extended mode bit 2 or bit 6 is 1. In latch mode, a write to $8000-$9FFF or $C000-$FFFF loads the latch with the written byte. Outside latch mode such writes leave it unchanged.
- R6: A write anywhere in $A000-$BFFF never changes the CHR latch.
- R7: An $A001 write (address bits 15:13 = 101, bit 0 = 1) with data bit 5 clear enters CFG_PLAIN. In that state ram_cfg_on is 0, wram_en is data bit 7, wram_wp is data bit 6, wram_bank is 0, chr_lo_ram is 0 and win_en is 1.
- R8: An $A001 write with data bit 5 set enters CFG_EXT. In that state ram_cfg_on is 1, wram_bank is data bits 1:0, chr_lo_ram is data bit 2, win_en is data bit 6, wram_en is data bit 7 and wram_wp is 0. A later write with bit 5 clear returns to CFG_PLAIN.
- R9: While win_en is 0, every write to $5000-$5FFF drives wram_ce and wram_we to 1 in the same cycle. It also drives wram_addr to {2'b10, 1'b1, address bits 11:0} and leaves all auxiliary registers unchanged, whatever the DIP match bit is.
- R10: An access to $6000-$7FFF drives wram_ce to wram_en and wram_addr to {wram_bank, address bits 12:0}. It drives wram_we to 1 only for a write with wram_en 1 and wram_wp 0.
- R11: wram_batt is 1 exactly when wram_ce is 1 and the addressed bank is 1 or 3 (wram_addr bit 13 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dip_sel | input | 3 | DIP setting choosing the window match bit |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| mode_reg | output | 8 | Mode register |
| prg_base | output | 8 | PRG base register |
| chr_base | output | 8 | CHR base register |
| ext_mode | output | 8 | Extended mode register |
| chr_latch | output | 8 | CHR data latch |
| latch_mode | output | 1 | Latch mode active |
| ram_cfg_on | output | 1 | RAM configuration state is CFG_EXT |
| win_en | output | 1 | Auxiliary window enabled |
| wram_en | output | 1 | Work RAM enabled |
| wram_wp | output | 1 | Work RAM write protected |
| chr_lo_ram | output | 1 | Low 8 KiB of CHR space is RAM |
| wram_bank | output | 2 | Selected 8 KiB work-RAM bank |
| wram_ce | output | 1 | Work-RAM chip enable |
| wram_we | output | 1 | Work-RAM write enable |
| wram_addr | output | 15 | Work-RAM address (bank, offset) |
| wram_batt | output | 1 | Access targets a battery-backed bank |

## Verification
A window write can fall in the same cycle as two rules that compete for it: the DIP register match and the redirection into work RAM. The bench first sends $A001 a byte with bit 5 set and bit 6 clear. It then writes to addresses whose match bit is set. It judges the outcome in two places: the same-cycle work-RAM strobes, and the auxiliary registers after the clock edge, which must be unchanged. A second overlap is the CHR latch. Its load and clear rules share one register, so the bench alternates loads at $8000/$C000/$FFFF, ignored writes in $A000-$BFFF and CHR base writes, and reads the latch after each one.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic {
        CFG_PLAIN = 1'b0,
        CFG_EXT   = 1'b1
    } cfg_state_e;

    localparam int AUX_REGS   = 4;
    localparam int REG_MODE   = 0;
    localparam int REG_PRG    = 1;
    localparam int REG_CHR    = 2;
    localparam int REG_EXT    = 3;

    localparam int ADDR_W     = 16;
    localparam int DIP_W      = 3;
    localparam int WIN_LSB    = 4;
    localparam int WBANK_W    = 2;
    localparam int WOFS_W     = 13;
    localparam int WADDR_W    = WBANK_W + WOFS_W;

endpackage

// File: rtl/awd_addr_decode.sv
module awd_addr_decode
    import awd_pkg::*;
(
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DIP_W-1:0]    dip_sel,
    input  logic                win_en,
    output logic [AUX_REGS-1:0] aux_we,
    output logic                redir_we,
    output logic                ramcfg_we,
    output logic                latch_rng_we,
    output logic                wram_rng
);

    localparam int MATCH_BITS = 1 << DIP_W;

    logic                  wr_cyc;
    logic                  in_window;
    logic [MATCH_BITS-1:0] match_field;
    logic                  match_hit;
    logic                  low_slot;

    always_comb begin
        wr_cyc      = bus_en && bus_wr;
        in_window   = (bus_addr[15:12] == 4'h5);
        match_field = bus_addr[WIN_LSB +: MATCH_BITS];
        match_hit   = match_field[dip_sel];
        low_slot    = (bus_addr[3:2] == 2'b00);
    end

    genvar gi;
    generate
        for (gi = 0; gi < AUX_REGS; gi++) begin : g_sel
            assign aux_we[gi] = wr_cyc && in_window && win_en && match_hit &&
                                low_slot && (bus_addr[1:0] == 2'(gi));
        end
    endgenerate

    always_comb begin
        redir_we     = wr_cyc && in_window && !win_en;
        ramcfg_we    = wr_cyc && (bus_addr[15:13] == 3'b101) && bus_addr[0];
        latch_rng_we = wr_cyc && ((bus_addr[15:13] == 3'b100) ||
                                  (bus_addr[15:14] == 2'b11));
        wram_rng     = bus_en && (bus_addr[15:13] == 3'b011);
    end

endmodule

// File: rtl/awd_aux_regs.sv
module awd_aux_regs
    import awd_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] PRG_BASE_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AUX_REGS-1:0] aux_we,
    input  logic                latch_rng_we,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   mode_q,
    output logic [DATA_W-1:0]   prg_q,
    output logic [DATA_W-1:0]   chr_q,
    output logic [DATA_W-1:0]   ext_q,
    output logic [DATA_W-1:0]   latch_q,
    output logic                latch_mode
);

    logic [DATA_W-1:0] regs_q [AUX_REGS];

    genvar gi;
    generate
        for (gi = 0; gi < AUX_REGS; gi++) begin : g_reg
            localparam logic [DATA_W-1:0] RST_VAL =
                (gi == REG_PRG) ? PRG_BASE_RST : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[gi] <= RST_VAL;
                end else if (aux_we[gi]) begin
                    regs_q[gi] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        mode_q     = regs_q[REG_MODE];
        prg_q      = regs_q[REG_PRG];
        chr_q      = regs_q[REG_CHR];
        ext_q      = regs_q[REG_EXT];
        latch_mode = mode_q[6] && (ext_q[2] || ext_q[6]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (aux_we[REG_CHR]) begin
            latch_q <= '0;
        end else if (latch_rng_we && latch_mode) begin
            latch_q <= wr_data;
        end
    end

endmodule

// File: rtl/awd_ram_cfg.sv
module awd_ram_cfg
    import awd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               cfg_on,
    output logic               win_en,
    output logic               ram_en,
    output logic               ram_wp,
    output logic               chr_lo_ram,
    output logic [WBANK_W-1:0] bank
);

    cfg_state_e        state_q, state_d;
    logic [DATA_W-1:0] cfg_q;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_q[DATA_W-1:8], cfg_q[5:3]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_PLAIN;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_we) begin
                cfg_q <= wr_data;
            end
        end
    end

    // transitions: to_ext on bit 5 set, to_plain on bit 5 clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_PLAIN: if (cfg_we && wr_data[5])  state_d = CFG_EXT;
            CFG_EXT:   if (cfg_we && !wr_data[5]) state_d = CFG_PLAIN;
        endcase
    end

    // outputs
    always_comb begin
        cfg_on     = 1'b0;
        win_en     = 1'b1;
        ram_en     = cfg_q[7];
        ram_wp     = 1'b0;
        chr_lo_ram = 1'b0;
        bank       = '0;
        unique case (state_q)
            CFG_PLAIN: begin
                ram_wp = cfg_q[6];
            end
            CFG_EXT: begin
                cfg_on     = 1'b1;
                win_en     = cfg_q[6];
                chr_lo_ram = cfg_q[2];
                bank       = cfg_q[WBANK_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/aux_window_decoder.sv
module aux_window_decoder
    import awd_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] PRG_BASE_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         dip_sel,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [15:0]        bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  mode_reg,
    output logic [DATA_W-1:0]  prg_base,
    output logic [DATA_W-1:0]  chr_base,
    output logic [DATA_W-1:0]  ext_mode,
    output logic [DATA_W-1:0]  chr_latch,
    output logic               latch_mode,
    output logic               ram_cfg_on,
    output logic               win_en,
    output logic               wram_en,
    output logic               wram_wp,
    output logic               chr_lo_ram,
    output logic [1:0]         wram_bank,
    output logic               wram_ce,
    output logic               wram_we,
    output logic [14:0]        wram_addr,
    output logic               wram_batt
);

    localparam logic [WBANK_W-1:0] REDIR_BANK = WBANK_W'(2);

    logic [AUX_REGS-1:0] aux_we;
    logic                redir_we;
    logic                ramcfg_we;
    logic                latch_rng_we;
    logic                wram_rng;

    awd_addr_decode u_dec (
        .bus_en       (bus_en),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .dip_sel      (dip_sel),
        .win_en       (win_en),
        .aux_we       (aux_we),
        .redir_we     (redir_we),
        .ramcfg_we    (ramcfg_we),
        .latch_rng_we (latch_rng_we),
        .wram_rng     (wram_rng)
    );

    awd_aux_regs #(
        .DATA_W       (DATA_W),
        .PRG_BASE_RST (PRG_BASE_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .aux_we       (aux_we),
        .latch_rng_we (latch_rng_we),
        .wr_data      (bus_wdata),
        .mode_q       (mode_reg),
        .prg_q        (prg_base),
        .chr_q        (chr_base),
        .ext_q        (ext_mode),
        .latch_q      (chr_latch),
        .latch_mode   (latch_mode)
    );

    awd_ram_cfg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (ramcfg_we),
        .wr_data    (bus_wdata),
        .cfg_on     (ram_cfg_on),
        .win_en     (win_en),
        .ram_en     (wram_en),
        .ram_wp     (wram_wp),
        .chr_lo_ram (chr_lo_ram),
        .bank       (wram_bank)
    );

    always_comb begin
        if (redir_we) begin
            wram_ce   = 1'b1;
            wram_we   = 1'b1;
            wram_addr = {REDIR_BANK, 1'b1, bus_addr[11:0]};
        end else begin
            wram_ce   = wram_rng && wram_en;
            wram_we   = wram_rng && wram_en && bus_wr && !wram_wp;
            wram_addr = {wram_bank, bus_addr[WOFS_W-1:0]};
        end
        wram_batt = wram_ce && wram_addr[WOFS_W];
    end

endmodule

// File: rtl/aux_window_decoder_chk.sv
module aux_window_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        dip_sel,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [15:0]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] mode_reg,
    input logic [DATA_W-1:0] prg_base,
    input logic [DATA_W-1:0] chr_base,
    input logic [DATA_W-1:0] ext_mode,
    input logic [DATA_W-1:0] chr_latch,
    input logic              latch_mode,
    input logic              ram_cfg_on,
    input logic              win_en,
    input logic              wram_en,
    input logic              chr_lo_ram,
    input logic [1:0]        wram_bank,
    input logic              wram_ce,
    input logic              wram_we,
    input logic [14:0]       wram_addr
);

    logic [7:0] mbits;
    logic       hit;
    logic       wr;
    logic       in_win;

    always_comb begin
        mbits  = bus_addr[11:4];
        hit    = mbits[dip_sel];
        wr     = bus_en && bus_wr;
        in_win = (bus_addr[15:12] == 4'h5);
    end

    // R3
    window_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && in_win && !hit) |=> ($stable(mode_reg) && $stable(prg_base) &&
                                    $stable(chr_base) && $stable(ext_mode) &&
                                    $stable(chr_latch)));

    // R4
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && in_win && win_en && hit && bus_addr[3:0] == 4'h2) |=> (chr_latch == '0));

    // R6
    latch_a000_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr[15:13] == 3'b101) |=> $stable(chr_latch));

    // R5
    latch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_win && !latch_mode) |=> $stable(chr_latch));

    // R7
    plain_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cfg_on |-> (wram_bank == 2'd0 && win_en && !chr_lo_ram));

    // R8
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr[15:13] == 3'b101 && bus_addr[0] && bus_wdata[5])
        |=> (ram_cfg_on && wram_bank == $past(bus_wdata[1:0])));

    // R9
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && in_win && !win_en) |-> (wram_ce && wram_we && wram_addr[14:12] == 3'b101));

    // R9
    redirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && in_win && !win_en) |=> ($stable(mode_reg) && $stable(prg_base) &&
                                       $stable(chr_base) && $stable(ext_mode)));

    // R10
    wram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr[15:13] == 3'b011 && !wram_en) |-> !wram_ce);

endmodule

bind aux_window_decoder aux_window_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dip_sel    (dip_sel),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .mode_reg   (mode_reg),
    .prg_base   (prg_base),
    .chr_base   (chr_base),
    .ext_mode   (ext_mode),
    .chr_latch  (chr_latch),
    .latch_mode (latch_mode),
    .ram_cfg_on (ram_cfg_on),
    .win_en     (win_en),
    .wram_en    (wram_en),
    .chr_lo_ram (chr_lo_ram),
    .wram_bank  (wram_bank),
    .wram_ce    (wram_ce),
    .wram_we    (wram_we),
    .wram_addr  (wram_addr)
);

// File: tb/aux_window_decoder_test.sv
module aux_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dip_sel = 3'd0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  mode_reg, prg_base, chr_base, ext_mode, chr_latch;
    logic        latch_mode, ram_cfg_on, win_en, wram_en, wram_wp, chr_lo_ram;
    logic [1:0]  wram_bank;
    logic        wram_ce, wram_we, wram_batt;
    logic [14:0] wram_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    aux_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .dip_sel(dip_sel), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mode_reg(mode_reg), .prg_base(prg_base), .chr_base(chr_base),
        .ext_mode(ext_mode), .chr_latch(chr_latch), .latch_mode(latch_mode),
        .ram_cfg_on(ram_cfg_on), .win_en(win_en), .wram_en(wram_en),
        .wram_wp(wram_wp), .chr_lo_ram(chr_lo_ram), .wram_bank(wram_bank),
        .wram_ce(wram_ce), .wram_we(wram_we), .wram_addr(wram_addr),
        .wram_batt(wram_batt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_cyc(input logic [15:0] a, input logic [7:0] d);
        drive(1'b1, a, d);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_reg, 8'h00);
        chk("R1 prg", prg_base, 8'h00);
        chk("R1 chr", chr_base, 8'h00);
        chk("R1 ext", ext_mode, 8'h00);
        chk("R1 latch", chr_latch, 8'h00);
        chk("R1 cfg", {ram_cfg_on, wram_en, win_en}, 3'b001);
    endtask

    task automatic t_reg_select();
        dip_sel = 3'd0;
        wr_cyc(16'h5010, 8'hA5);
        wr_cyc(16'h5011, 8'h3C);
        wr_cyc(16'h5012, 8'h81);
        wr_cyc(16'h5013, 8'h02);
        chk("R2 mode", mode_reg, 8'hA5);
        chk("R2 prg", prg_base, 8'h3C);
        chk("R2 chr", chr_base, 8'h81);
        chk("R2 ext", ext_mode, 8'h02);
        dip_sel = 3'd5;
        wr_cyc(16'h5201, 8'h77);
        chk("R2 dip5 prg", prg_base, 8'h77);
        wr_cyc(16'h5FF3, 8'h00);
        chk("R2 5FF3 ext", ext_mode, 8'h00);
    endtask

    task automatic t_miss();
        dip_sel = 3'd5;
        wr_cyc(16'h5011, 8'h11);
        chk("R3 nomatch prg", prg_base, 8'h77);
        wr_cyc(16'h5214, 8'h99);
        chk("R3 slot mode", mode_reg, 8'hA5);
        chk("R3 slot prg", prg_base, 8'h77);
        chk("R3 slot ext", ext_mode, 8'h00);
    endtask

    task automatic t_latch();
        dip_sel = 3'd0;
        wr_cyc(16'h5010, 8'h40);
        chk("R5 mode only", latch_mode, 1'b0);
        wr_cyc(16'h5013, 8'h04);
        chk("R5 mode on b2", latch_mode, 1'b1);
        wr_cyc(16'h8000, 8'h5A);
        chk("R5 load 8000", chr_latch, 8'h5A);
        wr_cyc(16'hA000, 8'h33);
        chk("R6 A000", chr_latch, 8'h5A);
        wr_cyc(16'hBFFE, 8'h34);
        chk("R6 BFFE", chr_latch, 8'h5A);
        wr_cyc(16'hFFFF, 8'hC3);
        chk("R5 load FFFF", chr_latch, 8'hC3);
        wr_cyc(16'h5012, 8'h10);
        chk("R4 clear", chr_latch, 8'h00);
        chk("R4 chr", chr_base, 8'h10);
        wr_cyc(16'h5013, 8'h40);
        wr_cyc(16'hC000, 8'h0F);
        chk("R5 load b6", chr_latch, 8'h0F);
        wr_cyc(16'h5013, 8'h00);
        chk("R5 mode off", latch_mode, 1'b0);
        wr_cyc(16'h9000, 8'h66);
        chk("R5 no load", chr_latch, 8'h0F);
    endtask

    task automatic t_plain();
        wr_cyc(16'hA001, 8'hC0);
        chk("R7 state", {ram_cfg_on, wram_en, wram_wp, win_en}, 4'b0111);
        chk("R7 bank", wram_bank, 2'd0);
        drive(1'b0, 16'h6123, 8'h00);
        chk("R10 rd ce/we", {wram_ce, wram_we}, 2'b10);
        chk("R10 rd addr", wram_addr, 15'h0123);
        chk("R11 bank0", wram_batt, 1'b0);
        idle();
        drive(1'b1, 16'h7FFF, 8'h55);
        chk("R10 wp blocks", {wram_ce, wram_we}, 2'b10);
        idle();
        wr_cyc(16'hA001, 8'h80);
        drive(1'b1, 16'h7FFF, 8'h55);
        chk("R10 wr", {wram_ce, wram_we}, 2'b11);
        chk("R10 wr addr", wram_addr, 15'h1FFF);
        idle();
        wr_cyc(16'hA001, 8'h00);
        drive(1'b0, 16'h6000, 8'h00);
        chk("R10 disabled", wram_ce, 1'b0);
        idle();
    endtask

    task automatic t_ext();
        dip_sel = 3'd0;
        wr_cyc(16'hA001, 8'hE2);
        chk("R8 enter", {ram_cfg_on, win_en, wram_en, wram_wp, chr_lo_ram}, 5'b11100);
        chk("R8 bank2", wram_bank, 2'd2);
        drive(1'b1, 16'h6010, 8'h01);
        chk("R10 ext we", {wram_ce, wram_we}, 2'b11);
        chk("R10 ext addr", wram_addr, 15'h4010);
        chk("R11 bank2", wram_batt, 1'b0);
        idle();
        wr_cyc(16'hA001, 8'hE7);
        chk("R8 bank3", {wram_bank, chr_lo_ram}, 3'b111);
        drive(1'b0, 16'h7000, 8'h00);
        chk("R10 bank3 addr", wram_addr, 15'h7000);
        chk("R11 bank3", wram_batt, 1'b1);
        idle();
        wr_cyc(16'hA001, 8'hA1);
        chk("R8 win off", {win_en, wram_bank}, 3'b001);
        drive(1'b1, 16'h5010, 8'hEE);
        chk("R9 strobes", {wram_ce, wram_we}, 2'b11);
        chk("R9 addr", wram_addr, 15'h5010);
        idle();
        chk("R9 mode held", mode_reg, 8'h40);
        drive(1'b1, 16'h5013, 8'hEF);
        chk("R9 addr 5013", wram_addr, 15'h5013);
        idle();
        chk("R9 ext held", ext_mode, 8'h00);
        wr_cyc(16'h5012, 8'h44);
        chk("R9 chr held", chr_base, 8'h10);
        wr_cyc(16'hA001, 8'h00);
        chk("R8 back plain", {ram_cfg_on, win_en, wram_bank}, 4'b0100);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_select();
        t_miss();
        t_latch();
        t_plain();
        t_ext();
        summary();
        $finish;
    end

endmodule